// File: doc/BRIEF.md
# Adaptive Synchronous Rectifier Gate Tuner

This block drives the gates of the two secondary-side synchronous rectifiers in a half-bridge resonant converter. Each rectifier channel follows one primary switch. Its gate rises together with that primary gate. It then stays high for a number of clock cycles that a small closed loop adjusts once per switching period. After each rectifier turn-off, the channel samples a comparator that reports body-diode conduction. If conduction is seen, the next pulse is one step longer. If it is not seen, the next pulse is one step shorter. The loop therefore settles into a one-step dither around the point where the diode barely conducts. This works whether the ideal turn-off falls before or after the primary switch opens, so it holds both below and above resonance.

Each channel also measures how long its primary gate was high in its most recent completed pulse. When the tuned width runs beyond that measured time plus the programmed dead time, the applied pulse is cut back to the measured time plus a short programmed extension. The extension is chosen smaller than the dead time. This keeps the rectifier from overlapping the opposite primary switch when the switching frequency jumps up faster than the loop can follow. With a 250 MHz logic clock, one width step is 4 ns.

Top module: `sr_gate_tuner`

## Requirements
- R1: A rectifier gate goes high at the first clock edge that samples its primary gate high after a low sample, so it is seen high one cycle after the primary input rises.
- R2: Once started, a rectifier gate stays high for exactly the applied width in clock cycles. This holds whether or not its primary gate has already fallen.
- R3: When the comparator decision after a turn-off is 1 (the body diode conducts), the channel's stored width for the following pulse is one cycle longer.
- R4: When that decision is 0, the stored width is one cycle shorter. A comparator alternating 1,0,1,0 makes consecutive pulse widths alternate between two neighbouring values.
- R5: The stored width saturates at W_MIN and W_MAX. It is W_MIN after reset.
- R6: The measured primary width is the number of clock edges that sampled the primary gate high in its latest completed pulse. No measurement exists before the first completed pulse. If the stored width exceeds measured + dead_time, the applied width is measured + ext_time. Otherwise the applied width is the stored width.
- R7: The comparator is synchronized through two flops. The decision uses the comparator level sampled at the clock edge samp_dly cycles after the edge that drops the rectifier gate.
- R8: The two channels keep separate widths, measurements and decisions. Stimulus on one channel leaves the other channel's pulses unchanged.
- R9: During and after reset both rectifier gates are low until a primary gate rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock; one width step per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pri_gate | input | 2 | Primary switch gate levels, bit 0 channel A, bit 1 channel B |
| diode_cmp | input | 2 | Body-diode conduction comparator per channel, 1 = conducting |
| dead_time | input | CNT_W | Dead time in cycles used in the overlap test |
| ext_time | input | CNT_W | Turn-off extension in cycles applied when clamped; must be below dead_time |
| samp_dly | input | SAMP_W | Cycles from rectifier turn-off to comparator sample |
| sr_gate | output | 2 | Rectifier gate drives, bit order as pri_gate |

## Verification
A wrong stored width cannot be observed directly. It first shows up as a pulse of the wrong length, which appears at the next rising edge of that channel's primary gate. The bench therefore compares both gates against a behavioural model on every cycle and also checks each pulse length. A wrong primary-width capture appears only when the clamp condition changes. For that reason the primary pulse is shortened right after the width reaches its ceiling, and the clamped length is checked on the second short pulse. A mistimed comparator sample is caught when a comparator that changes every cycle leads to a different width one period later.

// File: rtl/sr_tune_pkg.sv
package sr_tune_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;
endpackage

// File: rtl/sr_sync2.sv
module sr_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= d;
      out_q  <= meta_q;
    end
  end

  assign q = out_q;
endmodule

// File: rtl/sr_pw_meter.sv
module sr_pw_meter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pri,
  output logic             rise,
  output logic [CNT_W-1:0] pw_last
);
  logic             pri_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q;
  logic             fall;
  logic             cnt_en;

  assign rise = pri & ~pri_q;
  assign fall = ~pri & pri_q;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (rise) begin
      cnt_en = 1'b1;
      cnt_d  = CNT_W'(1);
    end else if (pri && (cnt_q != '1)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q  <= 1'b0;
      cnt_q  <= '0;
      last_q <= '1;
    end else begin
      pri_q <= pri;
      if (cnt_en) cnt_q  <= cnt_d;
      if (fall)   last_q <= cnt_q;
    end
  end

  assign pw_last = last_q;
endmodule

// File: rtl/sr_width_loop.sv
module sr_width_loop
  import sr_tune_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int SAMP_W = 3,
  parameter int W_MIN  = 4,
  parameter int W_MAX  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              off_evt,
  input  logic [SAMP_W-1:0] samp_dly,
  input  logic              cmp_s,
  output logic [CNT_W-1:0]  width
);
  localparam int               DLY_W  = SAMP_W + 1;
  localparam logic [CNT_W-1:0] WMIN_V = CNT_W'(W_MIN);
  localparam logic [CNT_W-1:0] WMAX_V = CNT_W'(W_MAX);

  logic             pend_q, pend_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic [CNT_W-1:0] wid_q, wid_d;
  logic             wid_en;
  adj_e             adj;

  always_comb begin
    pend_d = pend_q;
    dly_d  = dly_q;
    adj    = ADJ_NONE;
    if (pend_q) begin
      if (dly_q == '0) begin
        pend_d = 1'b0;
        adj    = cmp_s ? ADJ_UP : ADJ_DOWN;
      end else begin
        dly_d = dly_q - DLY_W'(1);
      end
    end
    if (off_evt) begin
      pend_d = 1'b1;
      dly_d  = {1'b0, samp_dly} + DLY_W'(1);
    end
  end

  always_comb begin
    wid_d  = wid_q;
    wid_en = 1'b0;
    case (adj)
      ADJ_UP: begin
        if (wid_q < WMAX_V) begin
          wid_d  = wid_q + CNT_W'(1);
          wid_en = 1'b1;
        end
      end
      ADJ_DOWN: begin
        if (wid_q > WMIN_V) begin
          wid_d  = wid_q - CNT_W'(1);
          wid_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dly_q  <= '0;
      wid_q  <= WMIN_V;
    end else begin
      pend_q <= pend_d;
      dly_q  <= dly_d;
      if (wid_en) wid_q <= wid_d;
    end
  end

  assign width = wid_q;
endmodule

// File: rtl/sr_pulse_gen.sv
module sr_pulse_gen #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] width,
  input  logic [CNT_W-1:0] pw_last,
  input  logic [CNT_W-1:0] dead_time,
  input  logic [CNT_W-1:0] ext_time,
  output logic             gate,
  output logic             off_evt
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] lim, clamped, app_sel, app_d, app_q;
  logic [SUM_W-1:0] cnt_q, cnt_d;
  logic             on_q, on_d;
  logic             done;
  logic             cnt_en;

  always_comb begin
    lim     = {1'b0, pw_last} + {1'b0, dead_time};
    clamped = {1'b0, pw_last} + {1'b0, ext_time};
    app_sel = ({1'b0, width} > lim) ? clamped : {1'b0, width};
    app_d   = (app_sel == '0) ? SUM_W'(1) : app_sel;
  end

  assign done    = on_q & (cnt_q >= app_q);
  assign off_evt = done & ~start;

  always_comb begin
    on_d   = on_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      on_d   = 1'b1;
      cnt_d  = SUM_W'(1);
      cnt_en = 1'b1;
    end else if (done) begin
      on_d = 1'b0;
    end else if (on_q) begin
      cnt_d  = cnt_q + SUM_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
      app_q <= SUM_W'(1);
    end else begin
      on_q <= on_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (start)  app_q <= app_d;
    end
  end

  assign gate = on_q;
endmodule

// File: rtl/sr_gate_tuner.sv
module sr_gate_tuner
  import sr_tune_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int SAMP_W = 3,
  parameter int W_MIN  = 4,
  parameter int W_MAX  = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pri_gate,
  input  logic [1:0]        diode_cmp,
  input  logic [CNT_W-1:0]  dead_time,
  input  logic [CNT_W-1:0]  ext_time,
  input  logic [SAMP_W-1:0] samp_dly,
  output logic [1:0]        sr_gate
);
  logic rst_meta_q, rst_int_q;
  logic [NCH-1:0][CNT_W-1:0] wid_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_q  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_q  <= rst_meta_q;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic             cmp_s;
    logic             rise;
    logic             off_evt;
    logic [CNT_W-1:0] pw_last;

    sr_sync2 u_sync (
      .clk   (clk),
      .rst_n (rst_int_q),
      .d     (diode_cmp[ch]),
      .q     (cmp_s)
    );

    sr_pw_meter #(.CNT_W(CNT_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_int_q),
      .pri     (pri_gate[ch]),
      .rise    (rise),
      .pw_last (pw_last)
    );

    sr_width_loop #(
      .CNT_W (CNT_W), .SAMP_W(SAMP_W), .W_MIN(W_MIN), .W_MAX(W_MAX)
    ) u_loop (
      .clk      (clk),
      .rst_n    (rst_int_q),
      .off_evt  (off_evt),
      .samp_dly (samp_dly),
      .cmp_s    (cmp_s),
      .width    (wid_vec[ch])
    );

    sr_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
      .clk       (clk),
      .rst_n     (rst_int_q),
      .start     (rise),
      .width     (wid_vec[ch]),
      .pw_last   (pw_last),
      .dead_time (dead_time),
      .ext_time  (ext_time),
      .gate      (sr_gate[ch]),
      .off_evt   (off_evt)
    );
  end
endmodule

// File: rtl/sr_tune_chk.sv
module sr_tune_chk #(
  parameter int CNT_W = 10,
  parameter int W_MIN = 4,
  parameter int W_MAX = 200
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            pri_gate,
  input logic [1:0]            sr_gate,
  input logic [1:0][CNT_W-1:0] wid
);
  for (genvar ch = 0; ch < 2; ch++) begin : g_chk
    logic [CNT_W:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else if (sr_gate[ch]) run_q <= run_q + (CNT_W+1)'(1);
      else run_q <= '0;
    end

    // R1
    rise_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pri_gate[ch]) |=> sr_gate[ch]);

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wid[ch]) |-> ((wid[ch] == $past(wid[ch]) + 1) || (wid[ch] + 1 == $past(wid[ch]))));

    // R5
    width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wid[ch] >= CNT_W'(W_MIN)) && (wid[ch] <= CNT_W'(W_MAX)));

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= (CNT_W+1)'(W_MAX));
  end
endmodule

bind sr_gate_tuner sr_tune_chk #(
  .CNT_W (CNT_W), .W_MIN(W_MIN), .W_MAX(W_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pri_gate (pri_gate),
  .sr_gate  (sr_gate),
  .wid      (wid_vec)
);

// File: tb/sim_sr_gate_tuner.sv
module sim_sr_gate_tuner;
  localparam int CW   = 10;
  localparam int SW   = 3;
  localparam int WMIN = 4;
  localparam int WMAX = 40;
  localparam int DEAD = 8;
  localparam int EXT  = 3;
  localparam int SDLY = 2;
  localparam int GAP  = 60;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    pri, cmp, sr;
  logic [CW-1:0] dead, ext;
  logic [SW-1:0] sd;

  always #5 clk = ~clk;

  sr_gate_tuner #(.CNT_W(CW), .SAMP_W(SW), .W_MIN(WMIN), .W_MAX(WMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .pri_gate(pri), .diode_cmp(cmp),
    .dead_time(dead), .ext_time(ext), .samp_dly(sd), .sr_gate(sr)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phase = "R9";

  int m_pq[2], m_on[2], m_cnt[2], m_app[2], m_pend[2], m_dly[2];
  int m_wid[2], m_pwc[2], m_pwm[2], m_s1[2], m_s2[2];
  int run[2], last_len[2];
  int ew[2], lp[2];

  // behavioural reference, one step per clock edge
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        m_pq[i] = 0; m_on[i] = 0; m_cnt[i] = 0; m_app[i] = 1; m_pend[i] = 0;
        m_dly[i] = 0; m_wid[i] = WMIN; m_pwc[i] = 0; m_pwm[i] = CMAX;
        m_s1[i] = 0; m_s2[i] = 0;
      end else begin
        int p, rise, fall, nw, np, nd, off;
        p = int'(pri[i]);
        rise = (p == 1 && m_pq[i] == 0) ? 1 : 0;
        fall = (p == 0 && m_pq[i] == 1) ? 1 : 0;
        np = m_pend[i]; nd = m_dly[i]; nw = m_wid[i]; off = 0;
        if (m_pend[i] == 1) begin
          if (m_dly[i] == 0) begin
            np = 0;
            if (m_s2[i] == 1) nw = (m_wid[i] < WMAX) ? m_wid[i] + 1 : WMAX;
            else nw = (m_wid[i] > WMIN) ? m_wid[i] - 1 : WMIN;
          end else nd = m_dly[i] - 1;
        end
        if (rise == 1) begin
          m_on[i] = 1; m_cnt[i] = 1;
          m_app[i] = (m_wid[i] > m_pwm[i] + int'(dead)) ? m_pwm[i] + int'(ext) : m_wid[i];
          if (m_app[i] == 0) m_app[i] = 1;
        end else if (m_on[i] == 1) begin
          if (m_cnt[i] >= m_app[i]) begin m_on[i] = 0; off = 1; end
          else m_cnt[i]++;
        end
        if (off == 1) begin np = 1; nd = int'(sd) + 1; end
        m_pend[i] = np; m_dly[i] = nd; m_wid[i] = nw;
        if (fall == 1) m_pwm[i] = m_pwc[i];
        if (rise == 1) m_pwc[i] = 1;
        else if (p == 1 && m_pwc[i] < CMAX) m_pwc[i]++;
        m_pq[i] = p; m_s2[i] = m_s1[i]; m_s1[i] = int'(cmp[i]);
      end
    end
  end

  // per-cycle comparison and pulse length capture
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (rst_n && !finished) begin
        total++;
        if (sr[i] !== 1'(m_on[i])) begin
          bad++;
          $display("FAIL %s ch%0d sr_gate=%0b expected %0b at %0t", phase, i, sr[i], m_on[i], $time);
        end
      end
      if (sr[i] === 1'b1) run[i]++;
      else begin
        if (run[i] > 0) last_len[i] = run[i];
        run[i] = 0;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic half(int ch, int len, bit rnd);
    pri[ch] = 1'b1;
    @(negedge clk);
    chk("R1", int'(sr[ch]), 1);
    for (int k = 1; k < len; k++) begin
      if (rnd) cmp[ch] = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    pri[ch] = 1'b0;
    for (int k = 0; k < GAP; k++) begin
      if (rnd) cmp[ch] = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
  endtask

  task automatic period(int len, bit ca, bit cb, string req);
    int e[2];
    bit c[2];
    c[0] = ca; c[1] = cb;
    for (int ch = 0; ch < 2; ch++)
      e[ch] = (lp[ch] >= 0 && ew[ch] > lp[ch] + DEAD) ? lp[ch] + EXT : ew[ch];
    phase = req;
    cmp = {cb, ca};
    half(0, len, 1'b0);
    chk(req, last_len[0], e[0]);
    half(1, len, 1'b0);
    chk(req, last_len[1], e[1]);
    for (int ch = 0; ch < 2; ch++) begin
      if (c[ch]) ew[ch] = (ew[ch] < WMAX) ? ew[ch] + 1 : WMAX;
      else ew[ch] = (ew[ch] > WMIN) ? ew[ch] - 1 : WMIN;
      lp[ch] = len;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pri = 2'b00; cmp = 2'b00;
    dead = CW'(DEAD); ext = CW'(EXT); sd = SW'(SDLY);
    run[0] = 0; run[1] = 0; last_len[0] = 0; last_len[1] = 0;
    ew[0] = WMIN; ew[1] = WMIN; lp[0] = -1; lp[1] = -1;
    repeat (4) @(negedge clk);
    chk("R9", int'(sr), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9", int'(sr), 0);

    // R5: start at the floor and stay there under "no conduction"
    period(50, 1'b0, 1'b0, "R5");
    period(50, 1'b0, 1'b0, "R5");
    // R3: growth by one step per period
    for (int n = 0; n < 6; n++) period(50, 1'b1, 1'b1, "R3");
    // R8: channels driven apart
    for (int n = 0; n < 4; n++) period(50, 1'b1, 1'b0, "R8");
    // R4: alternating comparator gives dithering widths
    for (int n = 0; n < 6; n++) period(50, 1'(n % 2), 1'((n + 1) % 2), "R4");
    // R5: push to the ceiling
    for (int n = 0; n < 40; n++) period(50, 1'b1, 1'b1, "R5");
    chk("R5", ew[0], WMAX);
    // R6 and R2: primary shortens, clamp engages on the second short pulse
    period(20, 1'b1, 1'b1, "R6");
    period(20, 1'b1, 1'b1, "R6");
    chk("R2", last_len[1], 20 + EXT);
    period(20, 1'b0, 1'b0, "R6");
    // R7: comparator changing every cycle, checked against the model
    phase = "R7";
    for (int n = 0; n < 8; n++) begin
      half(0, 30, 1'b1);
      half(1, 30, 1'b1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule